// File: doc/BRIEF.md
# Stream-to-Raster Video Output

This block turns a stream of active-picture pixels, produced in a fast processing clock domain, into a raster video signal in an independent pixel clock domain. Each input pixel carries three 8-bit colour planes side by side, plus a start-of-frame marker on the first pixel of a picture and an end-of-line marker on the last pixel of each line. The output carries the same colour planes, a data-enable, and active-low horizontal and vertical sync on wires of their own. The sync is never coded into the pixel data.

An asynchronous FIFO with Gray-coded pointers moves each pixel and its two markers across the clock boundary. It holds 1024 entries by default. On the pixel side, a free-running timing generator frames an 800x480 active window with blanking. The front porch, sync and back porch are 40, 48 and 88 pixels per line, and 13, 3 and 32 lines per frame. A small lock controller takes pixels from the FIFO only inside the active window. It starts a picture only when a start-of-frame pixel sits at the FIFO head exactly as the window opens. When the stream runs dry or loses line alignment, the controller blanks the rest of the frame, records the fault, and locks again at the next start of frame.

The block is used between a pixel-processing pipeline and a panel or display transmitter. Backpressure on the input side absorbs the difference between the stream rate and the raster rate.

Top module: `vid_stream_out`

## Requirements
- R1: A line lasts ACT_W+H_FP+H_SYNC+H_BP pixel clocks. out_hsync_n is low for exactly H_SYNC clocks, starting H_FP clocks after the last active pixel of the line.
- R2: A frame lasts ACT_H+V_FP+V_SYNC+V_BP lines. out_vsync_n is low for exactly V_SYNC whole lines, starting V_FP lines after the last active line. out_de is never high while out_vsync_n is low.
- R3: out_de is high only for the ACT_W x ACT_H active pixels of each frame. out_rgb is all zero whenever out_de is low.
- R4: A shown pixel leaves the block unchanged and in raster order. The colour bus packs red in bits 23:16, green in 15:8 and blue in 7:0, on both the input and the output.
- R5: A picture starts only at the first active pixel of an output frame, and only if the FIFO head carries the start-of-frame marker. Any pixels queued ahead of that marker are dropped.
- R6: in_ready is low while the FIFO is full. A pixel is taken when in_valid and in_ready are both high, and no taken pixel is lost or repeated.
- R7: If the FIFO is empty when a locked active pixel is due, that pixel and the rest of the frame are black. The sticky flag out_underflow is raised, and the block locks again at the next start of frame.
- R8: If, while locked, the head pixel's end-of-line marker disagrees with the pixel being the last of its line, or a start-of-frame marker shows up anywhere but the first pixel, the rest of the frame is black. The sticky flag out_misalign is raised, and the block locks again at the next start of frame.
- R9: During reset, out_de is 0, both syncs are 1, out_rgb is 0 and both flags are 0.
- R10: Black frames shown while still waiting for the first start of frame raise neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Processing clock for the input stream |
| sys_rst_n | input | 1 | Active-low asynchronous reset, input side |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of a line |
| in_rgb | input | 24 | Pixel colour, red high byte |
| pix_clk | input | 1 | Pixel output clock |
| pix_rst_n | input | 1 | Active-low asynchronous reset, output side |
| out_de | output | 1 | Active pixel on out_rgb |
| out_hsync_n | output | 1 | Horizontal sync, active low |
| out_vsync_n | output | 1 | Vertical sync, active low |
| out_rgb | output | 24 | Output pixel colour, zero in blanking |
| out_underflow | output | 1 | Sticky: stream ran dry while locked |
| out_misalign | output | 1 | Sticky: line or frame markers out of step while locked |

## Verification
The bench uses a tiny 8x4 raster and checks every output cycle against a line and frame position it counts itself. Each input pixel carries its own coordinates and frame number, so a dropped, repeated or shifted pixel cannot pass as correct. A single script covers several patterns: leading junk ahead of the first start of frame, which tells a correct drop apart from a late lock; continuous frames that keep the FIFO full, which exercises backpressure; a frame cut short and followed by a long gap, which isolates underflow from misalignment; and a frame with an early end-of-line marker, which isolates misalignment from underflow. For each frame shown after a fault, the bench checks the exact number of pixels that survive and which frame locks next.

// File: rtl/vso_pkg.sv
package vso_pkg;

  // Bits per colour plane.
  localparam int unsigned CW = 8;

  typedef struct packed {
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
  } rgb_t;

  // One FIFO entry: frame/line markers travel with the pixel.
  typedef struct packed {
    logic sof;
    logic eol;
    rgb_t px;
  } fifo_word_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_state_e;

endpackage

// File: rtl/vso_rst_sync.sv
// Asynchronous assert, synchronous release.
module vso_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/vso_sync.sv
// Two-flop synchroniser for a Gray-coded pointer.
module vso_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/vso_afifo.sv
// Dual-clock FIFO, Gray pointers, head word visible without a pop.
module vso_afifo #(
  parameter int AW = 10,
  parameter int DW = 26
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wbin_q, wbin_d, wgray_q, wgray_d, rgray_w;
  logic [AW:0]   rbin_q, rbin_d, rgray_q, rgray_d, wgray_r;
  logic          full, push, pull;

  vso_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w));
  vso_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r));

  // Write side
  assign full     = (wgray_q == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
  assign wr_ready = ~full & wrst_n;
  assign push     = wr_valid & wr_ready;

  always_comb begin
    wbin_d  = wbin_q + {{AW{1'b0}}, push};
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem_q[wbin_q[AW-1:0]] <= wr_data;
  end

  // Read side
  assign rd_empty = (rgray_q == wgray_r);
  assign pull     = rd_pop & ~rd_empty;
  assign rd_data  = mem_q[rbin_q[AW-1:0]];

  always_comb begin
    rbin_d  = rbin_q + {{AW{1'b0}}, pull};
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end
endmodule

// File: rtl/vso_timing.sv
// Free-running raster counters; active window first, then porch/sync/porch.
module vso_timing #(
  parameter int ACT_W  = 800,
  parameter int ACT_H  = 480,
  parameter int H_FP   = 40,
  parameter int H_SYNC = 48,
  parameter int H_BP   = 88,
  parameter int V_FP   = 13,
  parameter int V_SYNC = 3,
  parameter int V_BP   = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic tg_act,
  output logic tg_first,
  output logic tg_last_col,
  output logic tg_hs_n,
  output logic tg_vs_n
);
  localparam int H_TOT = ACT_W + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = ACT_H + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_ACT  = HW'(ACT_W);
  localparam logic [HW-1:0] H_ALST = HW'(ACT_W - 1);
  localparam logic [HW-1:0] HS_BEG = HW'(ACT_W + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(ACT_W + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_ACT  = VW'(ACT_H);
  localparam logic [VW-1:0] VS_BEG = VW'(ACT_H + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(ACT_H + V_FP + V_SYNC);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;

  always_comb begin
    h_d = h_q + 1'b1;
    v_d = v_q;
    if (h_q == H_LAST) begin
      h_d = '0;
      v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign tg_act      = (h_q < H_ACT) && (v_q < V_ACT);
  assign tg_first    = (h_q == '0) && (v_q == '0);
  assign tg_last_col = (h_q == H_ALST);
  assign tg_hs_n     = !((h_q >= HS_BEG) && (h_q < HS_END));
  assign tg_vs_n     = !((v_q >= VS_BEG) && (v_q < VS_END));
endmodule

// File: rtl/vid_stream_out.sv
module vid_stream_out
  import vso_pkg::*;
#(
  parameter int ACT_W   = 800,
  parameter int ACT_H   = 480,
  parameter int H_FP    = 40,
  parameter int H_SYNC  = 48,
  parameter int H_BP    = 88,
  parameter int V_FP    = 13,
  parameter int V_SYNC  = 3,
  parameter int V_BP    = 32,
  parameter int FIFO_AW = 10
) (
  input  logic          sys_clk,
  input  logic          sys_rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic [3*CW-1:0] in_rgb,
  input  logic          pix_clk,
  input  logic          pix_rst_n,
  output logic          out_de,
  output logic          out_hsync_n,
  output logic          out_vsync_n,
  output logic [3*CW-1:0] out_rgb,
  output logic          out_underflow,
  output logic          out_misalign
);
  localparam int DW = $bits(fifo_word_t);

  logic        wrst_n, rrst_n;
  fifo_word_t  wr_word, head;
  logic [DW-1:0] head_raw;
  logic        empty, pop, show;
  logic        tg_act, tg_first, tg_last_col, tg_hs_n, tg_vs_n;
  lock_state_e st_q, st_d;
  logic        unf_q, unf_d, mis_q, mis_d;
  logic        de_q, hs_q, vs_q;
  logic [3*CW-1:0] rgb_q, rgb_d;

  vso_rst_sync u_wrst (.clk(sys_clk), .arst_n(sys_rst_n), .rst_n_o(wrst_n));
  vso_rst_sync u_rrst (.clk(pix_clk), .arst_n(pix_rst_n), .rst_n_o(rrst_n));

  assign wr_word = {in_sof, in_eol, in_rgb};

  vso_afifo #(.AW(FIFO_AW), .DW(DW)) u_fifo (
    .wclk(sys_clk), .wrst_n(wrst_n), .wr_valid(in_valid), .wr_data(wr_word),
    .wr_ready(in_ready),
    .rclk(pix_clk), .rrst_n(rrst_n), .rd_pop(pop), .rd_data(head_raw),
    .rd_empty(empty)
  );

  assign head = fifo_word_t'(head_raw);

  vso_timing #(
    .ACT_W(ACT_W), .ACT_H(ACT_H), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_tg (
    .clk(pix_clk), .rst_n(rrst_n), .tg_act(tg_act), .tg_first(tg_first),
    .tg_last_col(tg_last_col), .tg_hs_n(tg_hs_n), .tg_vs_n(tg_vs_n)
  );

  // Lock controller: hunts for a frame start, then streams until a fault.
  always_comb begin
    st_d  = st_q;
    unf_d = unf_q;
    mis_d = mis_q;
    pop   = 1'b0;
    show  = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (!empty) begin
          if (!head.sof) begin
            pop = 1'b1;                       // stale pixel ahead of a frame start
          end else if (tg_act && tg_first) begin
            pop   = 1'b1;
            show  = 1'b1;
            st_d  = ST_LOCK;
          end
        end
      end
      ST_LOCK: begin
        if (tg_act) begin
          if (empty) begin
            unf_d = 1'b1;
            st_d  = ST_HUNT;
          end else if ((head.sof != tg_first) || (head.eol != tg_last_col)) begin
            mis_d = 1'b1;
            st_d  = ST_HUNT;
          end else begin
            pop  = 1'b1;
            show = 1'b1;
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
    rgb_d = show ? head.px : '0;
  end

  always_ff @(posedge pix_clk or negedge rrst_n) begin
    if (!rrst_n) begin
      st_q  <= ST_HUNT;
      unf_q <= 1'b0;
      mis_q <= 1'b0;
      de_q  <= 1'b0;
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
      rgb_q <= '0;
    end else begin
      st_q  <= st_d;
      unf_q <= unf_d;
      mis_q <= mis_d;
      de_q  <= tg_act;
      hs_q  <= tg_hs_n;
      vs_q  <= tg_vs_n;
      rgb_q <= rgb_d;
    end
  end

  assign out_de        = de_q;
  assign out_hsync_n   = hs_q;
  assign out_vsync_n   = vs_q;
  assign out_rgb       = rgb_q;
  assign out_underflow = unf_q;
  assign out_misalign  = mis_q;
endmodule

// File: rtl/vso_chk.sv
module vso_chk #(
  parameter int H_SYNC = 48
) (
  input logic        pix_clk,
  input logic        pix_rst_n,
  input logic        out_de,
  input logic        out_hsync_n,
  input logic        out_vsync_n,
  input logic [23:0] out_rgb,
  input logic        out_underflow,
  input logic        out_misalign
);
  int unsigned hs_len_q;

  always_ff @(posedge pix_clk or negedge pix_rst_n) begin
    if (!pix_rst_n)        hs_len_q <= 0;
    else if (!out_hsync_n) hs_len_q <= hs_len_q + 1;
    else                   hs_len_q <= 0;
  end

  // R1
  p_hs_width_r1: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    $rose(out_hsync_n) |-> (hs_len_q == H_SYNC));

  // R2
  p_no_de_in_vsync_r2: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    !out_vsync_n |-> !out_de);

  // R3
  p_blank_black_r3: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    !out_de |-> (out_rgb == '0));

  // R7
  p_underflow_sticky_r7: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    out_underflow |=> out_underflow);

  // R8
  p_misalign_sticky_r8: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    out_misalign |=> out_misalign);
endmodule

bind vid_stream_out vso_chk #(.H_SYNC(H_SYNC)) chk_i (
  .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .out_de(out_de),
  .out_hsync_n(out_hsync_n), .out_vsync_n(out_vsync_n), .out_rgb(out_rgb),
  .out_underflow(out_underflow), .out_misalign(out_misalign)
);

// File: tb/vid_stream_out_tb_top.sv
module vid_stream_out_tb_top;
  localparam int W = 8, H = 4;
  localparam int HFP = 2, HS = 3, HBP = 2, VFP = 1, VS = 2, VBP = 1;
  localparam int HT = W + HFP + HS + HBP;
  localparam int VT = H + VFP + VS + VBP;
  localparam int NSHOW = 9;

  logic sys_clk = 1'b0, pix_clk = 1'b0;
  logic sys_rst_n = 1'b0, pix_rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [23:0] in_rgb = '0;
  logic in_ready, out_de, out_hsync_n, out_vsync_n, out_underflow, out_misalign;
  logic [23:0] out_rgb;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, saw_full = 1'b0;

  always #10 sys_clk = ~sys_clk;
  always #20 pix_clk = ~pix_clk;

  vid_stream_out #(
    .ACT_W(W), .ACT_H(H), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP), .FIFO_AW(4)
  ) dut_i (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_eol(in_eol), .in_rgb(in_rgb),
    .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .out_de(out_de),
    .out_hsync_n(out_hsync_n), .out_vsync_n(out_vsync_n), .out_rgb(out_rgb),
    .out_underflow(out_underflow), .out_misalign(out_misalign)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Caller is at a negedge of sys_clk; returns at the negedge after the transfer.
  task automatic push(input bit sof, input bit eol, input logic [23:0] rgb);
    in_valid = 1'b1; in_sof = sof; in_eol = eol; in_rgb = rgb;
    while (!in_ready) begin
      saw_full = 1'b1;
      @(negedge sys_clk);
    end
    @(negedge sys_clk);
    in_valid = 1'b0;
  endtask

  // Pixel word encodes its own position and frame number (never all zero).
  task automatic send_frame(input int k, input int len, input int bx, input int by);
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        if (y * W + x < len)
          push(y == 0 && x == 0, (x == W - 1) || (x == bx && y == by),
               {8'h80 | 8'(y), 8'h40 | 8'(x), 8'(k + 1)});
      end
    end
  endtask

  // Stimulus
  initial begin
    #90;
    // R9: outputs while reset is held
    check(out_de == 1'b0, "R9 de", out_de, 0);
    check(out_hsync_n == 1'b1, "R9 hsync", out_hsync_n, 1);
    check(out_vsync_n == 1'b1, "R9 vsync", out_vsync_n, 1);
    check(out_rgb == '0, "R9 rgb", out_rgb, 0);
    check(out_underflow == 1'b0 && out_misalign == 1'b0, "R9 flags",
          {out_underflow, out_misalign}, 0);
    #30;
    sys_rst_n = 1'b1;
    pix_rst_n = 1'b1;
    repeat (5) @(negedge sys_clk);
    for (int j = 0; j < 3; j++) push(1'b0, 1'b0, 24'h111111);   // R5: junk ahead of first SOF
    for (int k = 0; k < 3; k++) send_frame(k, W * H, -1, -1);
    send_frame(3, 10, -1, -1);                                  // R7: truncated
    repeat (900) @(negedge sys_clk);
    send_frame(4, W * H, -1, -1);
    send_frame(5, W * H, -1, -1);
    send_frame(6, W * H, 5, 1);                                 // R8: early end-of-line
    send_frame(7, W * H, -1, -1);
    send_frame(8, W * H, -1, -1);
  end

  // Monitor, sampling on the falling pixel clock edge
  initial begin : mon
    int bh, bv, npx, cur_id, sidx, exp_cnt;
    bit aligned, seen_black, exp_de, exp_hs, exp_vs;
    logic [23:0] px;
    aligned = 1'b0; bh = 0; bv = 0; npx = 0; cur_id = 0; sidx = 0; seen_black = 1'b0;
    @(posedge pix_rst_n);
    while (!done) begin
      @(negedge pix_clk);
      if (!aligned && out_de) aligned = 1'b1;
      if (aligned) begin
        exp_de = (bh < W) && (bv < H);
        exp_hs = !((bh >= W + HFP) && (bh < W + HFP + HS));
        exp_vs = !((bv >= H + VFP) && (bv < H + VFP + VS));
        check(out_de == exp_de, "R3 de", out_de, exp_de);
        check(out_hsync_n == exp_hs, "R1 hsync", out_hsync_n, exp_hs);
        check(out_vsync_n == exp_vs, "R2 vsync", out_vsync_n, exp_vs);
        px = out_rgb;
        if (!exp_de) begin
          check(px == '0, "R3 blank rgb", px, 0);
        end else if (px == '0) begin
          seen_black = 1'b1;
        end else begin
          check(!seen_black, "R7/R8 pixel after blackout", px, 0);
          check(px[23:16] == (8'h80 | 8'(bv)), "R4 red", px[23:16], 8'h80 | 8'(bv));
          check(px[15:8] == (8'h40 | 8'(bh)), "R4 green", px[15:8], 8'h40 | 8'(bh));
          if (npx == 0) cur_id = int'(px[7:0]);
          else check(int'(px[7:0]) == cur_id, "R4 blue", px[7:0], cur_id);
          npx++;
        end
        if (bh == HT - 1 && bv == VT - 1) begin
          if (npx > 0) begin
            exp_cnt = (sidx == 3) ? 10 : (sidx == 6) ? 8 + 5 : W * H;
            check(cur_id == sidx + 1, "R5 frame order", cur_id, sidx + 1);
            check(npx == exp_cnt, "R7/R8 shown pixels", npx, exp_cnt);
            check(out_underflow == (sidx >= 3), "R7 underflow flag", out_underflow, sidx >= 3);
            check(out_misalign == (sidx >= 6), "R8 misalign flag", out_misalign, sidx >= 6);
            sidx++;
            if (sidx == NSHOW) done = 1'b1;
          end else if (sidx == 0) begin
            check(!out_underflow && !out_misalign, "R10 no flag while hunting",
                  {out_underflow, out_misalign}, 0);
          end
          npx = 0; seen_black = 1'b0;
        end
        if (bh == HT - 1) begin
          bh = 0;
          bv = (bv == VT - 1) ? 0 : bv + 1;
        end else begin
          bh++;
        end
      end
    end
  end

  // Watchdog and summary
  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge sys_clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d frames expected %0d", 0, NSHOW);
    end
    check(saw_full, "R6 backpressure seen", saw_full, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule